// File: doc/BRIEF.md
# Two-Port Ownership Token Bank

This block holds a small set of one-bit ownership tokens that two agents, called the left side and the right side, use to agree on who may touch a shared resource. The tokens are kept apart from any data storage. Each side has its own select, write strobe, address and data buses. The low three address bits pick one of eight tokens.

A side asks for a token by writing 0 and gives it back by writing 1. It then reads the token to learn whether it is now the holder. A request made while the other side holds the token is remembered. When the holder lets go, the token passes straight to the waiting side.

Everything is synchronous to one clock and uses an active-low asynchronous reset. A read is sampled at the clock edge and kept in a per-side output register until that side reads again.

Top module: `dual_token_bank`

## Requirements
- R1: The token index is address bits [2:0]. Address bits above bit 2 have no effect, and each of the eight tokens keeps its state independently of the others.
- R2: Only write data bit 0 matters. Bit 0 = 0 requests the token, bit 0 = 1 releases it or withdraws a request, and all other data bits are ignored.
- R3: A read returns 0 on every output bit when the reading side holds the token and 1 on every bit otherwise. A free token therefore reads all ones on both sides.
- R4: While one side holds a token, a request from the other side leaves what both sides read unchanged. A request from the holder has no effect.
- R5: When the holder releases a token that the other side has requested, the other side owns it from the next cycle and the token is never seen as free.
- R6: A release written by the side that does not hold the token clears only that side's own pending request. The holder keeps the token.
- R7: The read output register loads only on a clock edge where its own side reads. It holds that value through any later writes from either side, and a write from the other side in the same cycle as the read does not change the value read.
- R8: When both sides request the same free token in the same cycle, the left side obtains it and the right side's request stays pending.
- R9: Reset makes every token free, clears every pending request and sets both read outputs to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lft_sel | input | 1 | Left side token access select |
| lft_wr | input | 1 | Left side write (1) or read (0) |
| lft_addr | input | 14 | Left side address; bits [2:0] pick the token |
| lft_wdata | input | 16 | Left side write data; bit 0 is used |
| lft_rdata | output | 16 | Left side registered read word |
| rgt_sel | input | 1 | Right side token access select |
| rgt_wr | input | 1 | Right side write (1) or read (0) |
| rgt_addr | input | 14 | Right side address; bits [2:0] pick the token |
| rgt_wdata | input | 16 | Right side write data; bit 0 is used |
| rgt_rdata | output | 16 | Right side registered read word |

## Verification
The hardest state to reach is a token that is held by one side while the other side has a request waiting, with a release arriving from one side or the other. Stimulus reaches it by having the right side request a token the left side already holds. The left side then either releases it, which tests the hand-over, or the waiting side withdraws its request first, after which the release must leave the token free. A same-cycle request by both sides, and a read taken in the very cycle the other side releases, are driven from the vector table. A reset is also applied while a request is pending.

// File: rtl/dtb_pkg.sv
package dtb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Next holder of a token from the current holder and both sides' wishes.
  // A holder that still wants the token keeps it; otherwise the left side
  // has priority over the right side.
  function automatic owner_e pick_owner(owner_e cur, logic want_l, logic want_r);
    owner_e nxt;
    if (cur == OWN_LEFT && want_l)        nxt = OWN_LEFT;
    else if (cur == OWN_RIGHT && want_r)  nxt = OWN_RIGHT;
    else if (want_l)                      nxt = OWN_LEFT;
    else if (want_r)                      nxt = OWN_RIGHT;
    else                                  nxt = OWN_NONE;
    return nxt;
  endfunction

  // Next state of one side's wish bit.
  function automatic logic next_want(logic cur, logic req, logic rel);
    logic nxt;
    if (req)      nxt = 1'b1;
    else if (rel) nxt = 1'b0;
    else          nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/dtb_port_dec.sv
module dtb_port_dec #(
  parameter int NTOK   = 8,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NTOK)
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx,
  output logic              rd,
  output logic [NTOK-1:0]   req_v,
  output logic [NTOK-1:0]   rel_v
);

  logic wr_hit;
  logic unused_bits;

  assign idx         = addr[IDX_W-1:0];
  assign rd          = sel & ~wr;
  assign wr_hit      = sel & wr;
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar k = 0; k < NTOK; k++) begin : g_tok
    logic hit;
    assign hit      = wr_hit & (idx == IDX_W'(k));
    assign req_v[k] = hit & ~wdata[0];
    assign rel_v[k] = hit &  wdata[0];
  end

endmodule

// File: rtl/dtb_token.sv
module dtb_token
  import dtb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);

  logic   want_l, want_r;
  logic   want_l_n, want_r_n;
  owner_e owner, owner_n;

  always_comb begin
    want_l_n = next_want(want_l, l_req, l_rel);
    want_r_n = next_want(want_r, r_req, r_rel);
    owner_n  = pick_owner(owner, want_l_n, want_r_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_l <= 1'b0;
      want_r <= 1'b0;
      owner  <= OWN_NONE;
    end else begin
      want_l <= want_l_n;
      want_r <= want_r_n;
      owner  <= owner_n;
    end
  end

  assign own_l  = (owner == OWN_LEFT);
  assign own_r  = (owner == OWN_RIGHT);
  assign pend_l = want_l & ~own_l;
  assign pend_r = want_r & ~own_r;

endmodule

// File: rtl/dtb_rd_reg.sv
module dtb_rd_reg #(
  parameter int NTOK   = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NTOK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NTOK-1:0]   own,
  output logic [DATA_W-1:0] rdata
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= 1'b1;
    else if (rd) flag_q <= ~own[idx];
  end

  assign rdata = {DATA_W{flag_q}};

endmodule

// File: rtl/dual_token_bank.sv
module dual_token_bank #(
  parameter int NTOK   = 8,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_sel,
  input  logic              lft_wr,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic [DATA_W-1:0] lft_wdata,
  output logic [DATA_W-1:0] lft_rdata,
  input  logic              rgt_sel,
  input  logic              rgt_wr,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic [DATA_W-1:0] rgt_wdata,
  output logic [DATA_W-1:0] rgt_rdata
);

  localparam int IDX_W = $clog2(NTOK);

  logic [IDX_W-1:0] l_idx, r_idx;
  logic             l_rd, r_rd;
  logic [NTOK-1:0]  l_req, l_rel, r_req, r_rel;
  logic [NTOK-1:0]  own_l, own_r, pend_l, pend_r;

  dtb_port_dec #(.NTOK(NTOK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
    .sel(lft_sel), .wr(lft_wr), .addr(lft_addr), .wdata(lft_wdata),
    .idx(l_idx), .rd(l_rd), .req_v(l_req), .rel_v(l_rel)
  );

  dtb_port_dec #(.NTOK(NTOK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
    .sel(rgt_sel), .wr(rgt_wr), .addr(rgt_addr), .wdata(rgt_wdata),
    .idx(r_idx), .rd(r_rd), .req_v(r_req), .rel_v(r_rel)
  );

  for (genvar k = 0; k < NTOK; k++) begin : g_tok
    dtb_token u_tok (
      .clk(clk), .rst_n(rst_n),
      .l_req(l_req[k]), .l_rel(l_rel[k]),
      .r_req(r_req[k]), .r_rel(r_rel[k]),
      .own_l(own_l[k]), .own_r(own_r[k]),
      .pend_l(pend_l[k]), .pend_r(pend_r[k])
    );
  end

  dtb_rd_reg #(.NTOK(NTOK), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd(l_rd), .idx(l_idx), .own(own_l), .rdata(lft_rdata)
  );

  dtb_rd_reg #(.NTOK(NTOK), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd(r_rd), .idx(r_idx), .own(own_r), .rdata(rgt_rdata)
  );

endmodule

// File: rtl/dtb_chk.sv
module dtb_chk #(
  parameter int NTOK   = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NTOK-1:0]   own_l,
  input logic [NTOK-1:0]   own_r,
  input logic [NTOK-1:0]   pend_l,
  input logic [NTOK-1:0]   pend_r,
  input logic [NTOK-1:0]   l_req,
  input logic [NTOK-1:0]   l_rel,
  input logic [NTOK-1:0]   r_req,
  input logic [NTOK-1:0]   r_rel,
  input logic              l_rd,
  input logic              r_rd,
  input logic [DATA_W-1:0] lft_rdata,
  input logic [DATA_W-1:0] rgt_rdata
);

  // R3
  always @(posedge clk) begin
    if (rst_n) begin
      rdata_uniform_chk: assert ((lft_rdata == '0 || lft_rdata == '1) &&
                                 (rgt_rdata == '0 || rgt_rdata == '1));
    end
  end

  // R7
  lft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(lft_rdata));

  // R7
  rgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> $stable(rgt_rdata));

  for (genvar k = 0; k < NTOK; k++) begin : g_tok
    // R4
    left_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[k] && r_req[k] && !l_rel[k]) |=> (own_l[k] && !own_r[k]));

    // R5
    hand_to_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[k] && l_rel[k] && pend_r[k] && !r_rel[k]) |=> own_r[k]);

    // R5
    hand_to_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r[k] && r_rel[k] && pend_l[k] && !l_rel[k]) |=> own_l[k]);

    // R6
    cancel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[k] && r_rel[k] && !l_rel[k]) |=> (own_l[k] && !pend_r[k]));

    // R8
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!own_l[k] && !own_r[k] && l_req[k] && r_req[k]) |=> (own_l[k] && pend_r[k]));
  end

endmodule

bind dual_token_bank dtb_chk #(.NTOK(NTOK), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r),
  .l_req(l_req), .l_rel(l_rel), .r_req(r_req), .r_rel(r_rel),
  .l_rd(l_rd), .r_rd(r_rd),
  .lft_rdata(lft_rdata), .rgt_rdata(rgt_rdata)
);

// File: tb/dual_token_bank_tb.sv
`timescale 1ns/1ps
module dual_token_bank_tb;

  localparam int AW = 14;
  localparam int DW = 16;
  localparam logic [1:0] OI = 2'd0;  // idle
  localparam logic [1:0] OW = 2'd1;  // write
  localparam logic [1:0] OR = 2'd2;  // read

  typedef struct packed {
    logic [3:0]    req;
    logic [1:0]    lop;
    logic [AW-1:0] la;
    logic [DW-1:0] ld;
    logic [1:0]    rop;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    logic          el;
    logic          er;
  } vec_t;

  // Expected el/er: bit value every output bit shows after that cycle.
  localparam vec_t TBL [24] = '{
    '{4'd2, OW, 14'h2A8B, 16'hFFFE, OI, 14'h0000, 16'h0000, 1'b1, 1'b1}, // R2 L asks tok3, noisy upper bits
    '{4'd1, OR, 14'h0003, 16'h0000, OR, 14'h1FFB, 16'h0000, 1'b0, 1'b1}, // R1 R3
    '{4'd4, OI, 14'h0000, 16'h0000, OW, 14'h0003, 16'hFFFE, 1'b0, 1'b1}, // R4 R asks held tok3
    '{4'd4, OR, 14'h0003, 16'h0000, OR, 14'h0003, 16'h0000, 1'b0, 1'b1}, // R4 unchanged view
    '{4'd4, OW, 14'h0003, 16'h0000, OI, 14'h0000, 16'h0000, 1'b0, 1'b1}, // R4 holder asks again
    '{4'd5, OW, 14'h0003, 16'h0001, OI, 14'h0000, 16'h0000, 1'b0, 1'b1}, // R5 L releases
    '{4'd5, OR, 14'h0003, 16'h0000, OR, 14'h0003, 16'h0000, 1'b1, 1'b0}, // R5 R now holds
    '{4'd6, OW, 14'h0003, 16'hFFFE, OI, 14'h0000, 16'h0000, 1'b1, 1'b0}, // R6 L pending
    '{4'd6, OW, 14'h0003, 16'hFFFF, OI, 14'h0000, 16'h0000, 1'b1, 1'b0}, // R6 L withdraws
    '{4'd6, OI, 14'h0000, 16'h0000, OW, 14'h0003, 16'h0001, 1'b1, 1'b0}, // R6 R releases
    '{4'd6, OR, 14'h0003, 16'h0000, OR, 14'h0003, 16'h0000, 1'b1, 1'b1}, // R6 free, not L
    '{4'd8, OW, 14'h0005, 16'hFFFE, OW, 14'h3FFD, 16'hFFFE, 1'b1, 1'b1}, // R8 tie on tok5
    '{4'd8, OR, 14'h0005, 16'h0000, OR, 14'h0005, 16'h0000, 1'b0, 1'b1}, // R8 left wins
    '{4'd7, OW, 14'h0005, 16'h0001, OR, 14'h0005, 16'h0000, 1'b0, 1'b1}, // R7 read sees pre-release state
    '{4'd5, OR, 14'h0005, 16'h0000, OR, 14'h0005, 16'h0000, 1'b1, 1'b0}, // R5 R pending got it
    '{4'd1, OW, 14'h3FF8, 16'hFFFE, OR, 14'h0005, 16'h0000, 1'b1, 1'b0}, // R1 L asks tok0
    '{4'd1, OR, 14'h0000, 16'h0000, OR, 14'h0008, 16'h0000, 1'b0, 1'b1}, // R1 tok0 L-held
    '{4'd1, OR, 14'h0005, 16'h0000, OI, 14'h0000, 16'h0000, 1'b1, 1'b1}, // R1 tok5 still R
    '{4'd2, OW, 14'h0000, 16'h0001, OW, 14'h0005, 16'h0001, 1'b1, 1'b1}, // R2 both release
    '{4'd2, OR, 14'h0005, 16'h0000, OR, 14'h0000, 16'h0000, 1'b1, 1'b1}, // R2 both free
    '{4'd2, OW, 14'h0007, 16'h8000, OI, 14'h0000, 16'h0000, 1'b1, 1'b1}, // R2 bit0=0 asks
    '{4'd3, OR, 14'h0007, 16'h0000, OR, 14'h0007, 16'h0000, 1'b0, 1'b1}, // R3
    '{4'd2, OW, 14'h0007, 16'h7FFF, OI, 14'h0000, 16'h0000, 1'b0, 1'b1}, // R2 bit0=1 releases
    '{4'd3, OR, 14'h0007, 16'h0000, OI, 14'h0000, 16'h0000, 1'b1, 1'b1}  // R3 free reads 1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lft_sel = 1'b0, lft_wr = 1'b0;
  logic [AW-1:0] lft_addr = '0;
  logic [DW-1:0] lft_wdata = '0;
  logic [DW-1:0] lft_rdata;
  logic          rgt_sel = 1'b0, rgt_wr = 1'b0;
  logic [AW-1:0] rgt_addr = '0;
  logic [DW-1:0] rgt_wdata = '0;
  logic [DW-1:0] rgt_rdata;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  dual_token_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .lft_sel(lft_sel), .lft_wr(lft_wr), .lft_addr(lft_addr),
    .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
    .rgt_sel(rgt_sel), .rgt_wr(rgt_wr), .rgt_addr(rgt_addr),
    .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata)
  );

  task automatic check(input int req, input string what,
                       input logic [DW-1:0] act, input logic bitv);
    logic [DW-1:0] exp;
    exp = {DW{bitv}};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one rising edge.
  task automatic cyc(input logic [1:0] lop, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input logic [1:0] rop, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    lft_sel = (lop != OI); lft_wr = (lop == OW); lft_addr = la; lft_wdata = ld;
    rgt_sel = (rop != OI); rgt_wr = (rop == OW); rgt_addr = ra; rgt_wdata = rd;
    @(negedge clk);
    lft_sel = 1'b0; rgt_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(9, "left after reset", lft_rdata, 1'b1);
    check(9, "right after reset", rgt_rdata, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 24; i++) begin
      cyc(TBL[i].lop, TBL[i].la, TBL[i].ld, TBL[i].rop, TBL[i].ra, TBL[i].rd);
      check(int'(TBL[i].req), $sformatf("step %0d left", i), lft_rdata, TBL[i].el);
      check(int'(TBL[i].req), $sformatf("step %0d right", i), rgt_rdata, TBL[i].er);
    end

    // R7: register keeps value after the holder releases
    cyc(OW, 14'h0004, 16'hFFFE, OI, 14'h0, 16'h0);
    cyc(OR, 14'h0004, 16'h0000, OI, 14'h0, 16'h0);
    check(7, "left holds tok4", lft_rdata, 1'b0);
    cyc(OW, 14'h0004, 16'h0001, OI, 14'h0, 16'h0);
    cyc(OI, 14'h0, 16'h0, OW, 14'h0004, 16'hFFFE);
    cyc(OI, 14'h0, 16'h0, OI, 14'h0, 16'h0);
    check(7, "left register held", lft_rdata, 1'b0);
    cyc(OI, 14'h0, 16'h0, OR, 14'h0004, 16'h0000);
    check(7, "right holds tok4", rgt_rdata, 1'b0);

    // R9: reset during a pending request
    cyc(OW, 14'h0004, 16'hFFFE, OI, 14'h0, 16'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check(9, "left in reset", lft_rdata, 1'b1);
    check(9, "right in reset", rgt_rdata, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(OR, 14'h0004, 16'h0000, OR, 14'h0004, 16'h0000);
    check(9, "left tok4 free", lft_rdata, 1'b1);
    check(9, "right tok4 free", rgt_rdata, 1'b1);
    cyc(OI, 14'h0, 16'h0, OW, 14'h0004, 16'hFFFE);
    cyc(OR, 14'h0004, 16'h0000, OR, 14'h0004, 16'h0000);
    check(9, "left pending cleared", lft_rdata, 1'b1);
    check(9, "right gets tok4", rgt_rdata, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule